// File: doc/BRIEF.md
# BCD calendar clock counter

This block keeps the time of day and the calendar date in packed BCD. It has eight byte-wide registers: hundredths of a second, seconds, minutes, hours, day of week, date, month and a two-digit year. They advance on a single-cycle tick strobe, which the surrounding logic raises once every 10 ms. Hours can run in 24-hour form or in 12-hour form with a PM flag. The date rolls over at the true end of each month, and February is 29 days long in leap years.

A host sets the clock with a parallel load that writes all eight registers in one cycle. All eight registers can be read at the same time on a 64-bit output bus. The load port has no back-pressure: a load is taken in every cycle where `ld_en` is high. Two control flags are held in spare bits of the day-of-week register and are also driven out as plain outputs. One is a halt flag that freezes counting. The other is a flag that tells chip-level logic to disregard its external reset pin.

Register k sits in byte k of both buses (bits 8k+7..8k). From k = 0 to 7 the registers are: hundredths, seconds, minutes, hours, day, date, month, year.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the bus reads year 00, month 01, date 01, day 01, hours 00 (24-hour mode), minutes 00, seconds 00, hundredths 00, that is 64'h00010101_00000000. Both flag outputs are 0.
- R2: Each tick while running advances the hundredths. Hundredths roll from 99 to 00 and carry into seconds. Seconds roll from 59 to 00 and carry into minutes. Minutes roll from 59 to 00 and carry into hours. Without a tick, nothing changes.
- R3: The date rolls to 01 and carries into the month after day 30 of April, June, September and November, and after day 31 of the other months except February.
- R4: February ends on day 29 when the year value is divisible by 4 (00 included), and on day 28 otherwise.
- R5: Hours bit 7 = 1 selects 12-hour mode. In that mode bit 5 is PM and bits 4..0 hold the BCD hour from 1 to 12. The sequence 11 to 12 flips PM. The sequence 12 to 01 keeps PM. The step from 11 PM to 12 AM carries into the date.
- R6: Hours bit 7 = 0 selects 24-hour mode. In that mode bits 5..0 hold the BCD hour from 00 to 23, with bit 5 set for hours 20 to 23. The step from 23 to 00 carries into the date.
- R7: Day bit 5 is the halt flag and drives `halt`. While it is 1, ticks change no register.
- R8: Day bit 4 is stored, reads back, and drives `rst_pin_ignore`. It has no effect on counting.
- R9: Bits that no field uses always read 0 after a load: seconds bit 7, minutes bit 7, hours bit 6, day bits 7, 6 and 3, date bits 7 and 6, month bits 7 to 5.
- R10: A load writes all eight registers on the next edge. When a tick arrives in the same cycle as a load, the load wins.
- R11: Day of week (bits 2..0) counts 1 to 7 and goes from 7 back to 1. It advances on every date carry. Month goes from 12 back to 01 and carries into the year. The year goes from 99 back to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe, one per hundredth of a second |
| ld_en | input | 1 | Load all eight registers from `ld_data` |
| ld_data | input | 64 | Load value, register k in byte k |
| time_q | output | 64 | Current registers, register k in byte k |
| halt | output | 1 | Halt flag (day bit 5) |
| rst_pin_ignore | output | 1 | Reset-ignore flag (day bit 4) |

## Verification
Some rules are checked on every cycle by assertions:
- each low counter and the month and year return to their first value at the top of their range;
- the PM flag flips on the 11-to-12 step, and 24-hour mode wraps at 23;
- the date returns to 01 on a carry, and the day of week never becomes zero after a step;
- a halted clock holds its bus, and a load wins over a tick.

Other rules can only be shown by the bench's scenarios, where a behavioural model follows every cycle:
- the length of each month and the leap-year choice, including year 00;
- the full chain of carries from 23:59:59.99 on 31 December 99;
- 12-hour midnight advancing the date;
- the masking of unused bits and the control flags.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_W  = 8;
  localparam int N_REGS = 8;
  localparam int BUS_W  = REG_W * N_REGS;

  typedef logic [REG_W-1:0] bcd_byte_t;

  // Binary value of a two-digit BCD byte
  function automatic bcd_byte_t bcd2bin(input bcd_byte_t b);
    return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
  endfunction

  // BCD increment by one
  function automatic bcd_byte_t bcd_inc(input bcd_byte_t b);
    return (b[3:0] == 4'd9) ? {b[7:4] + 4'd1, 4'd0} : {b[7:4], b[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/rtc_bcd_wrap.sv
module rtc_bcd_wrap
  import rtc_pkg::*;
#(
  parameter bcd_byte_t LO   = 8'd0,
  parameter bcd_byte_t HI   = 8'd99,
  parameter bcd_byte_t KEEP = 8'hFF
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ld,
  input  bcd_byte_t ld_val,
  input  logic      step,
  output bcd_byte_t q,
  output logic      carry
);
  localparam bcd_byte_t LO_BCD = 8'((LO / 10) * 16 + (LO % 10));

  assign carry = step && (bcd2bin(q) >= HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= LO_BCD;
    else if (ld)   q <= ld_val & KEEP;
    else if (step) q <= carry ? LO_BCD : bcd_inc(q);
  end

  AST_WRAP_TO_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && bcd2bin(q) >= HI) |=> (q == LO_BCD)); // R2
endmodule

// File: rtl/rtc_hour_unit.sv
module rtc_hour_unit
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ld,
  input  bcd_byte_t ld_val,
  input  logic      step,
  output bcd_byte_t hr_q,
  output logic      carry
);
  bcd_byte_t hr_d, inc12, inc24, bin12, bin24;

  assign inc12 = bcd_inc({3'b000, hr_q[4:0]});
  assign inc24 = bcd_inc({2'b00, hr_q[5:0]});
  assign bin12 = bcd2bin({3'b000, hr_q[4:0]});
  assign bin24 = bcd2bin({2'b00, hr_q[5:0]});

  always_comb begin
    hr_d  = hr_q;
    carry = 1'b0;
    if (step) begin
      if (hr_q[7]) begin
        if (bin12 == 8'd11) begin
          hr_d  = {2'b10, ~hr_q[5], 5'h12};
          carry = hr_q[5];
        end else if (bin12 >= 8'd12) begin
          hr_d  = {2'b10, hr_q[5], 5'h01};
        end else begin
          hr_d  = {hr_q[7:5], inc12[4:0]};
        end
      end else begin
        if (bin24 >= 8'd23) begin
          hr_d  = 8'h00;
          carry = 1'b1;
        end else begin
          hr_d  = {2'b00, inc24[5:0]};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  hr_q <= 8'h00;
    else if (ld) hr_q <= ld_val & 8'hBF;
    else         hr_q <= hr_d;
  end

  AST_PM_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && hr_q[7] && hr_q[4:0] == 5'h11) |=> (hr_q[5] != $past(hr_q[5]))); // R5
  AST_H24_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && !hr_q[7] && hr_q[5:0] == 6'h23) |=> (hr_q == 8'h00)); // R6
endmodule

// File: rtl/rtc_date_unit.sv
module rtc_date_unit
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ld,
  input  bcd_byte_t ld_day,
  input  bcd_byte_t ld_date,
  input  logic      step,
  input  bcd_byte_t month_q,
  input  bcd_byte_t year_q,
  output bcd_byte_t day_q,
  output bcd_byte_t date_q,
  output logic      carry
);
  logic      leap;
  bcd_byte_t mon_bin, last_day;

  // Divisible by 4: even tens with units 0/4/8, odd tens with units 2/6
  assign leap = year_q[4] ? (year_q[3:0] == 4'd2 || year_q[3:0] == 4'd6)
                          : (year_q[3:0] == 4'd0 || year_q[3:0] == 4'd4 ||
                             year_q[3:0] == 4'd8);
  assign mon_bin = bcd2bin(month_q);

  always_comb begin
    case (mon_bin)
      8'd2:                       last_day = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:    last_day = 8'd30;
      default:                    last_day = 8'd31;
    endcase
  end

  assign carry = step && (bcd2bin(date_q) >= last_day);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      day_q  <= 8'h01;
      date_q <= 8'h01;
    end else if (ld) begin
      day_q  <= ld_day & 8'h37;
      date_q <= ld_date & 8'h3F;
    end else if (step) begin
      day_q[2:0] <= (day_q[2:0] >= 3'd7) ? 3'd1 : day_q[2:0] + 3'd1;
      date_q     <= carry ? 8'h01 : bcd_inc(date_q);
    end
  end

  AST_DATE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (carry && !ld) |=> (date_q == 8'h01)); // R3
  AST_DOW_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld) |=> (day_q[2:0] != 3'd0)); // R11
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ld_en,
  input  logic [BUS_W-1:0] ld_data,
  output logic [BUS_W-1:0] time_q,
  output logic             halt,
  output logic             rst_pin_ignore
);
  localparam int N_LOW = 3;
  localparam bcd_byte_t HI_T   [N_LOW] = '{8'd99, 8'd59, 8'd59};
  localparam bcd_byte_t KEEP_T [N_LOW] = '{8'hFF, 8'h7F, 8'h7F};

  logic             run;
  logic [N_LOW-1:0] low_step, low_carry;
  bcd_byte_t        low_q [N_LOW];
  bcd_byte_t        hr_q, day_q, date_q, month_q, year_q;
  logic             hr_carry, date_carry, month_carry, year_carry;

  assign run      = tick && !day_q[5];
  assign low_step = {low_carry[N_LOW-2:0], run};

  for (genvar i = 0; i < N_LOW; i++) begin : g_low
    rtc_bcd_wrap #(.LO(8'd0), .HI(HI_T[i]), .KEEP(KEEP_T[i])) u_cnt (
      .clk(clk), .rst_n(rst_n), .ld(ld_en), .ld_val(ld_data[REG_W*i +: REG_W]),
      .step(low_step[i]), .q(low_q[i]), .carry(low_carry[i]));
  end

  rtc_hour_unit u_hour (
    .clk(clk), .rst_n(rst_n), .ld(ld_en), .ld_val(ld_data[REG_W*3 +: REG_W]),
    .step(low_carry[N_LOW-1]), .hr_q(hr_q), .carry(hr_carry));

  rtc_date_unit u_date (
    .clk(clk), .rst_n(rst_n), .ld(ld_en),
    .ld_day(ld_data[REG_W*4 +: REG_W]), .ld_date(ld_data[REG_W*5 +: REG_W]),
    .step(hr_carry), .month_q(month_q), .year_q(year_q),
    .day_q(day_q), .date_q(date_q), .carry(date_carry));

  rtc_bcd_wrap #(.LO(8'd1), .HI(8'd12), .KEEP(8'h1F)) u_month (
    .clk(clk), .rst_n(rst_n), .ld(ld_en), .ld_val(ld_data[REG_W*6 +: REG_W]),
    .step(date_carry), .q(month_q), .carry(month_carry));

  rtc_bcd_wrap #(.LO(8'd0), .HI(8'd99), .KEEP(8'hFF)) u_year (
    .clk(clk), .rst_n(rst_n), .ld(ld_en), .ld_val(ld_data[REG_W*7 +: REG_W]),
    .step(month_carry), .q(year_q), .carry(year_carry));

  assign time_q = {year_q, month_q, date_q, day_q, hr_q, low_q[2], low_q[1], low_q[0]};
  assign halt           = day_q[5];
  assign rst_pin_ignore = day_q[4];

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && halt) |=> $stable(time_q)); // R7
  AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (time_q[7:0] == $past(ld_data[7:0]))); // R10
  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (year_carry && !ld_en) |=> (year_q == 8'h00)); // R11
endmodule

// File: tb/tb_rtc_calendar.sv
`timescale 1ns/1ps
module tb_rtc_calendar;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        ld_en = 1'b0;
  logic [63:0] ld_data = '0;
  logic [63:0] time_q;
  logic        halt, rst_pin_ignore;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string tag = "R1";

  // behavioural reference state
  int hs, sec, mn, h, pm, m12, dow, hlt, ign, dt, mo, yr;

  always #2.5 clk = ~clk;

  rtc_calendar dut (.clk(clk), .rst_n(rst_n), .tick(tick), .ld_en(ld_en),
    .ld_data(ld_data), .time_q(time_q), .halt(halt), .rst_pin_ignore(rst_pin_ignore));

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int month_len(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [63:0] enc();
    logic [7:0] hb, db;
    if (m12 != 0) hb = {1'b1, 1'b0, pm[0], (h >= 10), 4'(h % 10)};
    else          hb = i2b(h);
    db = {2'b00, hlt[0], ign[0], 1'b0, 3'(dow)};
    return {i2b(yr), i2b(mo), i2b(dt), db, hb, i2b(mn), i2b(sec), i2b(hs)};
  endfunction

  task automatic model_reset();
    hs = 0; sec = 0; mn = 0; h = 0; pm = 0; m12 = 0;
    dow = 1; hlt = 0; ign = 0; dt = 1; mo = 1; yr = 0;
  endtask

  task automatic next_day();
    dow = (dow == 7) ? 1 : dow + 1;
    if (dt == month_len(mo, yr)) begin
      dt = 1;
      if (mo == 12) begin mo = 1; yr = (yr + 1) % 100; end
      else mo = mo + 1;
    end else dt = dt + 1;
  endtask

  task automatic next_hour();
    if (m12 != 0) begin
      if (h == 11) begin
        h = 12;
        if (pm != 0) begin pm = 0; next_day(); end
        else pm = 1;
      end else if (h == 12) h = 1;
      else h = h + 1;
    end else begin
      if (h == 23) begin h = 0; next_day(); end
      else h = h + 1;
    end
  endtask

  task automatic model_step(input logic t, input logic l, input logic [63:0] d);
    if (l) begin
      hs = b2i(d[7:0]); sec = b2i(d[15:8] & 8'h7F); mn = b2i(d[23:16] & 8'h7F);
      m12 = int'(d[31]);
      if (m12 != 0) begin pm = int'(d[29]); h = b2i(d[31:24] & 8'h1F); end
      else begin pm = 0; h = b2i(d[31:24] & 8'h3F); end
      dow = int'(d[34:32]); ign = int'(d[36]); hlt = int'(d[37]);
      dt = b2i(d[47:40] & 8'h3F); mo = b2i(d[55:48] & 8'h1F); yr = b2i(d[63:56]);
    end else if (t && hlt == 0) begin
      if (hs == 99) begin
        hs = 0;
        if (sec == 59) begin
          sec = 0;
          if (mn == 59) begin mn = 0; next_hour(); end
          else mn = mn + 1;
        end else sec = sec + 1;
      end else hs = hs + 1;
    end
  endtask

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic l, input logic [63:0] d);
    @(negedge clk);
    tick = t; ld_en = l; ld_data = d;
    @(posedge clk);
    #1;
    model_step(t, l, d);
    chk(tag, time_q, enc());
    chk(tag, {62'd0, halt, rst_pin_ignore}, {62'd0, hlt[0], ign[0]});
    tick = 1'b0; ld_en = 1'b0;
  endtask

  task automatic load_tick(input logic [63:0] d);
    cyc(1'b0, 1'b1, d);
    cyc(1'b1, 1'b0, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1", time_q, 64'h00010101_00000000);
    chk("R1", {62'd0, halt, rst_pin_ignore}, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    tag = "R2";
    repeat (250) cyc(1'b1, 1'b0, '0);
    for (int i = 0; i < 60; i++) cyc(i % 3 == 0, 1'b0, '0);
    cyc(1'b0, 1'b1, 64'h24061003_00595998);
    repeat (3) cyc(1'b1, 1'b0, '0);
    chk("R2", time_q[31:0], 32'h01000001);

    tag = "R6";
    cyc(1'b0, 1'b1, 64'h50071403_23595997);
    repeat (5) cyc(1'b1, 1'b0, '0);
    chk("R6", time_q[47:24], 24'h150400);
    cyc(1'b0, 1'b1, 64'h50071403_19595999);
    cyc(1'b1, 1'b0, '0);
    chk("R6", time_q[31:24], 8'h20);

    tag = "R11";
    load_tick(64'h99123107_23595999);
    chk("R11", time_q, 64'h00010101_00000000);

    tag = "R3";
    load_tick(64'h24043002_23595999);
    chk("R3", time_q[55:40], 16'h0501);
    load_tick(64'h24013102_23595999);
    chk("R3", time_q[55:40], 16'h0201);
    load_tick(64'h24053002_23595999);
    chk("R3", time_q[55:40], 16'h0531);

    tag = "R4";
    load_tick(64'h23022802_23595999);
    chk("R4", time_q[55:40], 16'h0301);
    load_tick(64'h24022802_23595999);
    chk("R4", time_q[55:40], 16'h0229);
    load_tick(64'h24022902_23595999);
    chk("R4", time_q[55:40], 16'h0301);
    load_tick(64'h00022802_23595999);
    chk("R4", time_q[55:40], 16'h0229);

    tag = "R5";
    load_tick(64'h24061003_91595999);
    chk("R5", time_q[47:24], 24'h1003B2);
    load_tick(64'h24061003_B2595999);
    chk("R5", time_q[47:24], 24'h1003A1);
    load_tick(64'h24061003_B1595999);
    chk("R5", time_q[47:24], 24'h110492);

    tag = "R7";
    cyc(1'b0, 1'b1, 64'h24061023_12345678);
    repeat (30) cyc(1'b1, 1'b0, '0);
    chk("R7", {time_q, 63'd0, halt}, {64'h24061023_12345678, 64'd1});
    cyc(1'b0, 1'b1, 64'h24061003_12345678);
    cyc(1'b1, 1'b0, '0);
    chk("R7", time_q[7:0], 8'h79);

    tag = "R8";
    cyc(1'b0, 1'b1, 64'h24061013_12345678);
    repeat (4) cyc(1'b1, 1'b0, '0);
    chk("R8", {time_q[39:32], 7'd0, rst_pin_ignore}, {8'h13, 8'h01});
    chk("R8", time_q[7:0], 8'h82);

    tag = "R9";
    cyc(1'b0, 1'b1, 64'h24E6C9CB_55B08142);
    chk("R9", time_q, 64'h24060903_15300142);

    tag = "R10";
    cyc(1'b1, 1'b1, 64'h31082505_14223399);
    chk("R10", time_q, 64'h31082505_14223399);
    cyc(1'b1, 1'b0, '0);
    chk("R10", time_q[15:0], 16'h3400);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule